// File: doc/BRIEF.md
# Two-Key Register Write-Protect Gate

This block sits between a 32-bit register bus and a peripheral's register file and decides which writes may reach it. Protected registers (time, alarm, interrupt-enable, status-clear, power-control and so on, all living downstream) accept a write only while the gate is open. The gate opens after software loads a first magic word into one key register and then a second magic word into a second key register. Any other value written to either key closes it again. Writing zero to both keys is the normal way to close it.

Writes that arrive while the gate is closed are dropped without any bus error. A sticky violation flag records that one was dropped, and software can read and clear it. Reads are never blocked. They return local state for the gate's own registers and the downstream read data for every other address. A small bank of scratch words is held inside the gate. These words can be read at any time but can be written only while the gate is open.

Top module: `wp_gate`

## Requirements
- R1: After reset the gate is closed (`unlocked` = 0), both key match flags read 0, `viol` is 0 and every scratch word reads 0.
- R2: Writing 0x83E70B13 to the first key register (offset 0x6C) and then 0x95A4F1E0 to the second key register (offset 0x70) opens the gate. `unlocked` goes high in the cycle after the second write.
- R3: Writing the correct second key while the first key does not hold its magic value leaves the gate closed, and the second key's match flag stays 0.
- R4: Any write to the first key clears the second key's match flag, and a non-magic value also clears the first key's flag. A non-magic write to the second key clears its own flag. Each of these closes the gate from the next cycle, and writing zero is such a write.
- R5: A write to a downstream address (any address that is not a scratch word, key or flag register) produces `dn_wr` in the same cycle, with `dn_addr` and `dn_wdata` equal to the bus values, only while the gate is open. Otherwise `dn_wr` stays 0.
- R6: The scratch words at offsets 0x60, 0x64 and 0x68 are updated by a write only while the gate is open. They can be read in either state.
- R7: A read of a downstream address returns `dn_rdata` unchanged whether the gate is open or closed.
- R8: A write to a downstream address or a scratch word while the gate is closed sets `viol` from the next cycle. It stays set until a write to offset 0x74 with data bit 0 = 1 clears it, and that clear works while the gate is closed.
- R9: The key registers read back their match flag in bit 0 and zeros in all other bits. Offset 0x74 reads `viol` in bit 0.
- R10: Writes to the key registers or to offset 0x74 never produce `dn_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| dn_wr | output | 1 | Qualified write strobe to downstream registers |
| dn_addr | output | 8 | Address forwarded downstream |
| dn_wdata | output | 32 | Write data forwarded downstream |
| dn_rdata | input | 32 | Read data from downstream registers |
| unlocked | output | 1 | Gate is open |
| viol | output | 1 | Sticky flag for a dropped write |

## Verification
The assertions assume that each bus cycle addresses exactly one register, so one write can never hit both key registers at once. They also assume that the bus address and data are stable around the clock edge that samples a write. The stimulus drives every input at the falling edge and holds it through the next rising edge. It picks addresses from the gate's own offsets or from random downstream words, so each write is decoded as one kind. Random key data is weighted toward the two magic words and zero, so the gate opens and closes many times during a run.

// File: rtl/wp_gate_pkg.sv
package wp_gate_pkg;

   typedef enum logic [2:0] {
      REG_DOWN    = 3'd0,
      REG_SCRATCH = 3'd1,
      REG_KEY0    = 3'd2,
      REG_KEY1    = 3'd3,
      REG_VIOL    = 3'd4
   } reg_kind_e;

endpackage

// File: rtl/wp_addr_decode.sv
module wp_addr_decode
   import wp_gate_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int N_SCRATCH    = 3,
   parameter int SCRATCH_BASE = 'h60,
   parameter int KEY0_OFS     = 'h6C,
   parameter int KEY1_OFS     = 'h70,
   parameter int VIOL_OFS     = 'h74,
   parameter bit VIOL_EN      = 1'b1,
   localparam int IDX_W       = (N_SCRATCH > 1) ? $clog2(N_SCRATCH) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_kind_e         kind,
   output logic [IDX_W-1:0]  scr_idx
);

   always_comb begin
      kind    = REG_DOWN;
      scr_idx = '0;
      for (int i = 0; i < N_SCRATCH; i++) begin
         if (addr == ADDR_W'(SCRATCH_BASE + 4 * i)) begin
            kind    = REG_SCRATCH;
            scr_idx = IDX_W'(i);
         end
      end
      if (addr == ADDR_W'(KEY0_OFS))
         kind = REG_KEY0;
      else if (addr == ADDR_W'(KEY1_OFS))
         kind = REG_KEY1;
      else if (VIOL_EN && addr == ADDR_W'(VIOL_OFS))
         kind = REG_VIOL;
   end

endmodule

// File: rtl/wp_key_unlock.sv
module wp_key_unlock #(
   parameter int                DATA_W   = 32,
   parameter logic [DATA_W-1:0] KEY0_VAL = DATA_W'(32'h83E7_0B13),
   parameter logic [DATA_W-1:0] KEY1_VAL = DATA_W'(32'h95A4_F1E0)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_key0,
   input  logic              wr_key1,
   input  logic [DATA_W-1:0] wdata,
   output logic              key0_ok,
   output logic              key1_ok,
   output logic              unlocked
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key0_ok <= 1'b0;
         key1_ok <= 1'b0;
      end else if (wr_key0) begin
         key0_ok <= (wdata == KEY0_VAL);
         key1_ok <= 1'b0;
      end else if (wr_key1) begin
         key1_ok <= (wdata == KEY1_VAL) && key0_ok;
      end
   end

   assign unlocked = key0_ok & key1_ok;

   assert_open_after_key1_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(wr_key1 && wdata == KEY1_VAL));

   assert_key1_needs_key0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_key1 && !wr_key0 && !key0_ok) |=> !key1_ok);

   assert_bad_key0_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_key0 && wdata != KEY0_VAL) |=> !unlocked);

   assert_bad_key1_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_key1 && wdata != KEY1_VAL) |=> !unlocked);

endmodule

// File: rtl/wp_scratch.sv
module wp_scratch #(
   parameter int DATA_W    = 32,
   parameter int N_SCRATCH = 3,
   localparam int IDX_W    = (N_SCRATCH > 1) ? $clog2(N_SCRATCH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              unlocked,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] words [N_SCRATCH];

   for (genvar g = 0; g < N_SCRATCH; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[g] <= '0;
         else if (wr_en && unlocked && idx == IDX_W'(g))
            words[g] <= wdata;
      end

      assert_scratch_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !unlocked |=> $stable(words[g]));
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < N_SCRATCH; i++)
         if (idx == IDX_W'(i)) rdata = words[i];
   end

endmodule

// File: rtl/wp_gate.sv
module wp_gate
   import wp_gate_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 32,
   parameter int N_SCRATCH    = 3,
   parameter int SCRATCH_BASE = 'h60,
   parameter int KEY0_OFS     = 'h6C,
   parameter int KEY1_OFS     = 'h70,
   parameter int VIOL_OFS     = 'h74,
   parameter bit VIOL_EN      = 1'b1,
   parameter logic [DATA_W-1:0] KEY0_VAL = DATA_W'(32'h83E7_0B13),
   parameter logic [DATA_W-1:0] KEY1_VAL = DATA_W'(32'h95A4_F1E0)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              dn_wr,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic [DATA_W-1:0] dn_rdata,
   output logic              unlocked,
   output logic              viol
);

   localparam int IDX_W = (N_SCRATCH > 1) ? $clog2(N_SCRATCH) : 1;

   if (DATA_W < 32) begin : g_bad_width
      $error("wp_gate: DATA_W must hold a 32-bit key");
   end
   if (N_SCRATCH < 1) begin : g_bad_count
      $error("wp_gate: at least one scratch word is needed");
   end
   if (SCRATCH_BASE + 4 * N_SCRATCH > KEY0_OFS || KEY0_OFS == KEY1_OFS ||
       VIOL_OFS == KEY0_OFS || VIOL_OFS == KEY1_OFS) begin : g_bad_map
      $error("wp_gate: local register offsets overlap");
   end
   if ((1 << ADDR_W) <= VIOL_OFS || (1 << ADDR_W) <= KEY1_OFS) begin : g_bad_addr
      $error("wp_gate: ADDR_W too narrow for the offsets");
   end

   reg_kind_e         kind;
   logic [IDX_W-1:0]  scr_idx;
   logic              key0_ok, key1_ok;
   logic [DATA_W-1:0] scr_rdata;
   logic              blocked;

   wp_addr_decode #(
      .ADDR_W(ADDR_W), .N_SCRATCH(N_SCRATCH), .SCRATCH_BASE(SCRATCH_BASE),
      .KEY0_OFS(KEY0_OFS), .KEY1_OFS(KEY1_OFS), .VIOL_OFS(VIOL_OFS), .VIOL_EN(VIOL_EN)
   ) u_dec (
      .addr(bus_addr), .kind(kind), .scr_idx(scr_idx)
   );

   wp_key_unlock #(
      .DATA_W(DATA_W), .KEY0_VAL(KEY0_VAL), .KEY1_VAL(KEY1_VAL)
   ) u_keys (
      .clk(clk), .rst_n(rst_n),
      .wr_key0(bus_wr && kind == REG_KEY0),
      .wr_key1(bus_wr && kind == REG_KEY1),
      .wdata(bus_wdata),
      .key0_ok(key0_ok), .key1_ok(key1_ok), .unlocked(unlocked)
   );

   wp_scratch #(
      .DATA_W(DATA_W), .N_SCRATCH(N_SCRATCH)
   ) u_scr (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_wr && kind == REG_SCRATCH),
      .unlocked(unlocked), .idx(scr_idx), .wdata(bus_wdata), .rdata(scr_rdata)
   );

   assign dn_wr    = bus_wr && kind == REG_DOWN && unlocked;
   assign dn_addr  = bus_addr;
   assign dn_wdata = bus_wdata;
   assign blocked  = bus_wr && !unlocked && (kind == REG_DOWN || kind == REG_SCRATCH);

   if (VIOL_EN) begin : g_viol
      logic viol_q;
      logic viol_clr;
      assign viol_clr = bus_wr && kind == REG_VIOL && bus_wdata[0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        viol_q <= 1'b0;
         else if (blocked)  viol_q <= 1'b1;
         else if (viol_clr) viol_q <= 1'b0;
      end
      assign viol = viol_q;

      assert_viol_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
         blocked |=> viol);

      assert_viol_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (viol && !(bus_wr && bus_addr == ADDR_W'(VIOL_OFS) && bus_wdata[0])) |=> viol);
   end else begin : g_no_viol
      assign viol = 1'b0;
   end

   always_comb begin
      case (kind)
         REG_SCRATCH: bus_rdata = scr_rdata;
         REG_KEY0:    bus_rdata = DATA_W'(key0_ok);
         REG_KEY1:    bus_rdata = DATA_W'(key1_ok);
         REG_VIOL:    bus_rdata = DATA_W'(viol);
         default:     bus_rdata = dn_rdata;
      endcase
   end

   assert_no_local_dn_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == ADDR_W'(KEY0_OFS) || bus_addr == ADDR_W'(KEY1_OFS))) |-> !dn_wr);

endmodule

// File: tb/sim_wp_gate.sv
module sim_wp_gate;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] K0 = 32'h83E7_0B13;
   localparam logic [31:0] K1 = 32'h95A4_F1E0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        dn_wr;
   logic [7:0]  dn_addr;
   logic [31:0] dn_wdata;
   logic [31:0] dn_rdata = '0;
   logic        unlocked, viol;

   int n_cmp = 0;
   int n_bad = 0;

   logic        m_k0 = 1'b0, m_k1 = 1'b0, m_viol = 1'b0;
   logic [31:0] m_scr [3] = '{32'h0, 32'h0, 32'h0};

   always #(CLK_PERIOD/2) clk = ~clk;

   wp_gate u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dn_wr(dn_wr),
      .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata),
      .unlocked(unlocked), .viol(viol)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // 0 down, 1 scratch, 2 key0, 3 key1, 4 flag
   function automatic int kind_of(input logic [7:0] a);
      if (a == 8'h60 || a == 8'h64 || a == 8'h68) return 1;
      if (a == 8'h6C) return 2;
      if (a == 8'h70) return 3;
      if (a == 8'h74) return 4;
      return 0;
   endfunction

   function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [31:0] dn);
      case (kind_of(a))
         1: return m_scr[(a - 8'h60) >> 2];
         2: return {31'b0, m_k0};
         3: return {31'b0, m_k1};
         4: return {31'b0, m_viol};
         default: return dn;
      endcase
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      int k;
      logic open;
      k = kind_of(a);
      open = m_k0 & m_k1;
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      #1;
      if (k == 0) begin
         chk("R5 dn_wr", {31'b0, dn_wr}, {31'b0, open});
         if (open) begin
            chk("R5 dn_addr", {24'b0, dn_addr}, {24'b0, a});
            chk("R5 dn_wdata", dn_wdata, d);
         end
      end else begin
         chk("R10 dn_wr", {31'b0, dn_wr}, 32'h0);
      end
      @(posedge clk);
      case (k)
         0: if (!open) m_viol = 1'b1;
         1: if (open) m_scr[(a - 8'h60) >> 2] = d; else m_viol = 1'b1;
         2: begin m_k0 = (d == K0); m_k1 = 1'b0; end
         3: m_k1 = (d == K1) && m_k0;
         default: if (d[0]) m_viol = 1'b0;
      endcase
      @(negedge clk);
      bus_wr = 1'b0;
      #1;
      chk("R2 R4 unlocked", {31'b0, unlocked}, {31'b0, m_k0 & m_k1});
      chk("R8 viol", {31'b0, viol}, {31'b0, m_viol});
   endtask

   task automatic rd(input string tag, input logic [7:0] a);
      logic [31:0] dn;
      dn = $urandom;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = a; dn_rdata = dn;
      #1;
      chk(tag, bus_rdata, exp_read(a, dn));
   endtask

   function automatic logic [7:0] pick_addr();
      int r;
      r = $urandom_range(0, 9);
      case (r)
         0: return 8'h60;
         1: return 8'h64;
         2: return 8'h68;
         3: return 8'h6C;
         4: return 8'h70;
         5: return 8'h74;
         6: return 8'({$urandom_range(0, 63), 2'b00});
         default: return 8'($urandom_range(0, 255));
      endcase
   endfunction

   function automatic logic [31:0] pick_data(input logic [7:0] a);
      int r;
      r = $urandom_range(0, 2);
      if (a == 8'h6C && r == 0) return K0;
      if (a == 8'h70 && r == 0) return K1;
      if (r == 1) return 32'h0;
      return $urandom;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 unlocked", {31'b0, unlocked}, 32'h0);
      chk("R1 viol", {31'b0, viol}, 32'h0);
      chk("R1 dn_wr", {31'b0, dn_wr}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      rd("R1 key0", 8'h6C);
      rd("R1 key1", 8'h70);
      for (int i = 0; i < 3; i++) rd("R1 scratch", 8'(8'h60 + 4 * i));

      // R3 second key first
      wr(8'h70, K1);
      rd("R3 key1 flag", 8'h70);
      chk("R3 still locked", {31'b0, unlocked}, 32'h0);
      // R6 R8 locked scratch and downstream writes dropped
      wr(8'h64, 32'hDEAD_BEEF);
      rd("R6 scratch locked", 8'h64);
      wr(8'h10, 32'h1234_5678);
      chk("R8 set", {31'b0, viol}, 32'h1);
      rd("R9 flag read", 8'h74);
      wr(8'h74, 32'h1);
      chk("R8 cleared locked", {31'b0, viol}, 32'h0);
      // R7 read while locked
      rd("R7 locked read", 8'h20);
      // R2 unlock
      wr(8'h6C, K0);
      rd("R9 key0 flag", 8'h6C);
      wr(8'h70, K1);
      chk("R2 open", {31'b0, unlocked}, 32'h1);
      rd("R9 key1 flag", 8'h70);
      wr(8'h20, 32'hA5A5_0001);
      wr(8'h68, 32'hCAFE_F00D);
      rd("R6 scratch open", 8'h68);
      rd("R7 open read", 8'h24);
      wr(8'h74, 32'h1);
      // R4 wrong key1 closes
      wr(8'h70, 32'h95A4_F1E1);
      chk("R4 bad key1", {31'b0, unlocked}, 32'h0);
      wr(8'h70, K1);
      chk("R4 key1 retry alone", {31'b0, unlocked}, 32'h1);
      // R4 zero both
      wr(8'h6C, 32'h0);
      wr(8'h70, 32'h0);
      chk("R4 zero locks", {31'b0, unlocked}, 32'h0);
      rd("R6 scratch kept", 8'h68);

      // random mix
      for (int n = 0; n < 2000; n++) begin
         logic [7:0] a;
         a = pick_addr();
         if ($urandom_range(0, 3) == 0) rd("R7 R9 random read", a);
         else wr(a, pick_data(a));
      end
      for (int i = 0; i < 3; i++) rd("R6 final scratch", 8'(8'h60 + 4 * i));

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule